// File: doc/BRIEF.md
# Four-Word Burst Address Sequencer

This block produces the word address that a synchronous memory array uses during a burst of four words. A new external address is captured when the advance/load control is low. While that control is high, the block moves through the remaining words of the aligned four-word group by changing only the two low address bits. The upper bits stay as they were loaded.

A static order input selects how the low bits are visited. In linear order they count upward and wrap. In interleaved order they are the loaded offset XOR a running two-bit count. A clock-enable input freezes the whole sequencer. The block keeps the loaded offset and the count apart. The current address is formed from them combinationally, and the count is also output as the burst position.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and on the first cycle after it, `arr_addr` is 0 and `burst_pos` is 0.
- R2: A rising clock edge with `clk_en`=1 and `adv_ld`=0 (load) makes `arr_addr` equal `ext_addr` and `burst_pos` equal 0 after that edge.
- R3: A rising clock edge with `clk_en`=1 and `adv_ld`=1 (advance) increments `burst_pos` by one, modulo 4.
- R4: With `order_sel`=0 (linear), `arr_addr[1:0]` equals (loaded offset + `burst_pos`) mod 4, so an offset of 3 gives 3,0,1,2.
- R5: With `order_sel`=1 (interleaved), `arr_addr[1:0]` equals the loaded offset XOR `burst_pos`, so an offset of 1 gives 1,0,3,2 and an offset of 3 gives 3,2,1,0.
- R6: Advancing never changes `arr_addr` bits above bit 1; they keep the value of the last loaded address.
- R7: Advancing from the fourth word returns to the loaded offset, with `burst_pos` back at 0.
- R8: An edge with `clk_en`=0 leaves `arr_addr` and `burst_pos` unchanged. At that edge `adv_ld` and `ext_addr` have no effect.
- R9: A load issued partway through a burst starts a new burst at once from the new address, and the old sequence is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| adv_ld | input | 1 | 0 loads `ext_addr`, 1 advances the burst |
| ext_addr | input | ADDR_W | External word address to load |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| arr_addr | output | ADDR_W | Address presented to the memory array |
| burst_pos | output | 2 | Position of the current word within the burst (0 to 3) |

## Verification
A load and a freeze can fall on the same edge. The bench provokes this by driving `adv_ld` low with a new `ext_addr` while `clk_en` is low. It judges the outcome by checking that the address and the position stay exactly as they were. A load can also coincide with an advance that is already under way. The bench provokes this by loading a different address in the middle of a burst. It then checks that the next cycle shows the new address at position 0, and that the following advances walk the new group in the order selected.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTLV  = 1'b1
    } order_e;

    function automatic logic [BEAT_W-1:0] low_of(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] cnt,
        input order_e            ord
    );
        if (ord == ORD_INTLV) begin
            return start ^ cnt;
        end
        return start + cnt;
    endfunction

endpackage

// File: rtl/bseq_state.sv
module bseq_state
    import bseq_pkg::*;
#(
    parameter int UPPER_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              adv_ld,
    input  logic [UPPER_W-1:0] ld_upper,
    input  logic [BEAT_W-1:0]  ld_low,
    output logic [UPPER_W-1:0] upper_o,
    output logic [BEAT_W-1:0]  start_o,
    output logic [BEAT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BEAT_W-1:0]  start;
        logic [BEAT_W-1:0]  cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (!adv_ld) begin
                st_d.upper = ld_upper;
                st_d.start = ld_low;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upper_o = st_q.upper;
    assign start_o = st_q.start;
    assign cnt_o   = st_q.cnt;

endmodule

// File: rtl/bseq_low_map.sv
module bseq_low_map
    import bseq_pkg::*;
(
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] cnt_i,
    input  logic              order_i,
    output logic [BEAT_W-1:0] low_o
);

    order_e ord;

    always_comb begin
        ord   = order_i ? ORD_INTLV : ORD_LINEAR;
        low_o = low_of(start_i, cnt_i, ord);
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              adv_ld,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [1:0]        burst_pos
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [UPPER_W-1:0] upper_q;
    logic [BEAT_W-1:0]  start_q;
    logic [BEAT_W-1:0]  cnt_q;
    logic [BEAT_W-1:0]  low_w;

    bseq_state #(.UPPER_W(UPPER_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .adv_ld   (adv_ld),
        .ld_upper (ext_addr[ADDR_W-1:BEAT_W]),
        .ld_low   (ext_addr[BEAT_W-1:0]),
        .upper_o  (upper_q),
        .start_o  (start_q),
        .cnt_o    (cnt_q)
    );

    bseq_low_map u_map (
        .start_i (start_q),
        .cnt_i   (cnt_q),
        .order_i (order_sel),
        .low_o   (low_w)
    );

    assign arr_addr  = {upper_q, low_w};
    assign burst_pos = cnt_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              adv_ld,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              order_sel,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [1:0]        burst_pos
);

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld) |=> (burst_pos == 2'd0 &&
            ($stable(order_sel) ? arr_addr == $past(ext_addr)
                                : arr_addr[ADDR_W-1:2] == $past(ext_addr[ADDR_W-1:2]))));

    // R3
    adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld) |=> burst_pos == $past(burst_pos) + 2'd1);

    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld) |=> arr_addr[ADDR_W-1:2] == $past(arr_addr[ADDR_W-1:2]));

    // R4
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && !order_sel) |=>
            (order_sel || arr_addr[1:0] == $past(arr_addr[1:0]) + 2'd1));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(burst_pos) && (!$stable(order_sel) || $stable(arr_addr))));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .adv_ld    (adv_ld),
    .ext_addr  (ext_addr),
    .order_sel (order_sel),
    .arr_addr  (arr_addr),
    .burst_pos (burst_pos)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          adv_ld = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] arr_addr;
    logic [1:0]    burst_pos;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .adv_ld    (adv_ld),
        .ext_addr  (ext_addr),
        .order_sel (order_sel),
        .arr_addr  (arr_addr),
        .burst_pos (burst_pos)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        clk_en = 1'b1; adv_ld = 1'b0; ext_addr = a;
        tick();
        chk("R2 addr", 32'(arr_addr), 32'(a));
        chk("R2 pos", 32'(burst_pos), 0);
        adv_ld = 1'b1; ext_addr = '0;
    endtask

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] k, input logic ord);
        return ord ? (s ^ k) : 2'(s + k);
    endfunction

    task automatic run_burst(input logic [AW-1:0] a, input logic ord, input string req);
        order_sel = ord;
        do_load(a);
        for (int k = 1; k < 4; k++) begin
            tick();
            chk(req, 32'(arr_addr[1:0]), 32'(exp_low(a[1:0], 2'(k), ord)));
            chk("R3", 32'(burst_pos), 32'(k));
            chk("R6", 32'(arr_addr[AW-1:2]), 32'(a[AW-1:2]));
        end
        tick();
        chk("R7 addr", 32'(arr_addr), 32'(a));
        chk("R7 pos", 32'(burst_pos), 0);
    endtask

    task automatic test_reset();
        #1;
        chk("R1 addr", 32'(arr_addr), 0);
        chk("R1 pos", 32'(burst_pos), 0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 addr after", 32'(arr_addr), 0);
        chk("R1 pos after", 32'(burst_pos), 0);
    endtask

    task automatic test_freeze();
        order_sel = 1'b0;
        do_load(19'h2A5B7);
        tick();
        clk_en = 1'b0;
        adv_ld = 1'b0;
        ext_addr = 19'h01230;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8 addr", 32'(arr_addr), 32'h2A5B4);
            chk("R8 pos", 32'(burst_pos), 1);
        end
        adv_ld = 1'b1;
        tick();
        chk("R8 adv frozen", 32'(burst_pos), 1);
        clk_en = 1'b1;
        tick();
        chk("R8 resume", 32'(arr_addr), 32'h2A5B5);
    endtask

    task automatic test_reload();
        order_sel = 1'b1;
        do_load(19'h11112);
        tick();
        tick();
        do_load(19'h4C0F1);
        tick();
        chk("R9 intlv", 32'(arr_addr), 32'h4C0F0);
        chk("R9 pos", 32'(burst_pos), 1);
        tick();
        chk("R9 intlv2", 32'(arr_addr), 32'h4C0F3);
    endtask

    initial begin
        test_reset();
        run_burst(19'h3F00B, 1'b0, "R4");
        run_burst(19'h12345, 1'b1, "R5");
        run_burst(19'h7FFFF, 1'b1, "R5");
        run_burst(19'h00006, 1'b0, "R4");
        test_freeze();
        test_reload();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule